// File: doc/BRIEF.md
# Paired-Channel PWM Clock Prescaler

This block makes the counting ticks for two neighbouring PWM channels. Two tick-enable inputs stand in for two clock domains: an oscillator tick and a bus tick. A source field picks one of them. The picked tick stream is then divided by a power of two, and the result goes to both channels. Each channel has its own gate. Each channel also has its own bypass, which lets that channel take the undivided picked stream in place of the divided one.

All logic runs on one system clock. A single-cycle write strobe captures the configuration: source, divider exponent, two gate bits and two bypass bits. Every write restarts the shared divide counter. Because of this, the first divided tick after a write always comes after a full divide interval. Each channel output is a registered tick and is fed straight to that channel's period counter.

Top module: `pwm_pair_clkdiv`

## Requirements
- R1: When the captured source field (`src_sel_i`, 2 bits) is 0, only `osc_tick_i` is counted. Any value from 1 to 3 selects `bus_tick_i`, and the other input is ignored.
- R2: With exponent M, a gated channel that is not bypassed gets exactly one tick for every 2^M selected source ticks. The divide counter only advances on a selected source tick.
- R3: An exponent write with a value of 9 to 15 is held as 8, so the channel divides by 256.
- R4: When a channel's gate bit is clear (bit 0 is channel 0, bit 1 is channel 1), that channel never produces a tick.
- R5: When a channel's bypass bit is set (bit 0 is channel 0, bit 1 is channel 1) and its gate bit is set, the channel produces one tick for every selected source tick. The other channel is not affected.
- R6: Both channels share one divided stream. Two channels with the same gate and bypass settings produce identical ticks.
- R7: A configuration write sets the divide counter back to zero. The first divided tick then appears on the output in the cycle after the 2^M-th selected source tick that follows the write.
- R8: Reset clears both gates, both bypass bits, the source and the exponent, so no channel ticks until a write opens a gate.
- R9: A channel tick output is registered. It goes high exactly one clock cycle after the source tick that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Oscillator source tick enable |
| bus_tick_i | input | 1 | Bus source tick enable |
| cfg_wr_i | input | 1 | Capture strobe for all configuration fields |
| src_sel_i | input | 2 | Source field: 0 selects oscillator, nonzero selects bus |
| div_exp_i | input | 4 | Divider exponent M, clamped to 8 |
| gate_i | input | 2 | Per-channel tick gate |
| bypass_i | input | 2 | Per-channel divider bypass |
| chan_tick_o | output | 2 | Per-channel counting tick |

## Verification
The hardest thing to observe from the ports is the divider phase. A free-running counter hides where its wrap point lies, and the exponent clamp is only visible over windows of hundreds of source ticks. The stimulus writes a configuration and then runs a fixed window of source ticks: oscillator ticks every cycle and bus ticks every other cycle. Starting every window from the restart makes the expected tick counts exact. Directed runs record the index of the first output tick after a write, including a rewrite made partway through a divide interval, so that the restart position and the one-cycle latency can be checked directly.

// File: rtl/pwm_clk_pkg.sv
package pwm_clk_pkg;
  localparam int unsigned NCH     = 2;
  localparam int unsigned SRC_W   = 2;
  localparam int unsigned EXP_W   = 4;
  localparam int unsigned MAX_EXP = 8;
  localparam int unsigned CNT_W   = MAX_EXP;

  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] e);
    return (e > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : e;
  endfunction
endpackage

// File: rtl/pwm_clk_cfg.sv
module pwm_clk_cfg
  import pwm_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [NCH-1:0]   gate_i,
  input  logic [NCH-1:0]   bypass_i,
  output logic             use_bus_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [NCH-1:0]   gate_o,
  output logic [NCH-1:0]   bypass_o,
  output logic             restart_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_bus_o <= 1'b0;
      exp_o     <= '0;
      gate_o    <= '0;
      bypass_o  <= '0;
    end else if (wr_i) begin
      use_bus_o <= |src_i;
      exp_o     <= clamp_exp(exp_i);
      gate_o    <= gate_i;
      bypass_o  <= bypass_i;
    end
  end

  // any write carries the exponent field, so any write restarts the divider
  assign restart_o = wr_i;
endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             bus_tick_i,
  input  logic             use_bus_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             restart_i,
  output logic             sel_tick_o,
  output logic             div_tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   mask_w;
  logic [CNT_W-1:0] mask;

  assign sel_tick_o = use_bus_i ? bus_tick_i : osc_tick_i;
  assign mask_w     = ({{CNT_W{1'b0}}, 1'b1} << exp_i) - 1'b1;
  assign mask       = mask_w[CNT_W-1:0];
  assign div_tick_o = sel_tick_o && ((cnt_q & mask) == mask);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (sel_tick_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_chan_gate.sv
module pwm_chan_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic bypass_i,
  input  logic sel_tick_i,
  input  logic div_tick_i,
  output logic tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= gate_i && (bypass_i ? sel_tick_i : div_tick_i);
  end
endmodule

// File: rtl/pwm_pair_clkdiv.sv
module pwm_pair_clkdiv
  import pwm_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             bus_tick_i,
  input  logic             cfg_wr_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [EXP_W-1:0] div_exp_i,
  input  logic [NCH-1:0]   gate_i,
  input  logic [NCH-1:0]   bypass_i,
  output logic [NCH-1:0]   chan_tick_o
);
  logic             use_bus;
  logic [EXP_W-1:0] exp_q;
  logic [NCH-1:0]   gate_q;
  logic [NCH-1:0]   bypass_q;
  logic             restart;
  logic             sel_tick;
  logic             div_tick;
  logic [CNT_W-1:0] div_cnt;

  pwm_clk_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .src_i     (src_sel_i),
    .exp_i     (div_exp_i),
    .gate_i    (gate_i),
    .bypass_i  (bypass_i),
    .use_bus_o (use_bus),
    .exp_o     (exp_q),
    .gate_o    (gate_q),
    .bypass_o  (bypass_q),
    .restart_o (restart)
  );

  pwm_tick_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .bus_tick_i (bus_tick_i),
    .use_bus_i  (use_bus),
    .exp_i      (exp_q),
    .restart_i  (restart),
    .sel_tick_o (sel_tick),
    .div_tick_o (div_tick),
    .cnt_o      (div_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_chan_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gate_i     (gate_q[c]),
      .bypass_i   (bypass_q[c]),
      .sel_tick_i (sel_tick),
      .div_tick_i (div_tick),
      .tick_o     (chan_tick_o[c])
    );
  end
endmodule

// File: rtl/pwm_pair_clkdiv_chk.sv
module pwm_pair_clkdiv_chk
  import pwm_clk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_wr_i,
  input logic             osc_tick_i,
  input logic             bus_tick_i,
  input logic [NCH-1:0]   chan_tick_o,
  input logic [NCH-1:0]   gate_q,
  input logic [NCH-1:0]   bypass_q,
  input logic [EXP_W-1:0] exp_q,
  input logic [CNT_W-1:0] div_cnt,
  input logic             sel_tick
);
  assert_exp_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q <= EXP_W'(MAX_EXP));

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_wr_i && !sel_tick) |=> $stable(div_cnt));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> div_cnt == '0);

  assert_tick_needs_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_tick_i && !bus_tick_i) |=> chan_tick_o == '0);

  assert_shared_stream_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q == '1 && bypass_q == '0) |=> chan_tick_o[0] == chan_tick_o[1]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_gate_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_q[c] |=> !chan_tick_o[c]);
    assert_bypass_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_q[c] && bypass_q[c] && sel_tick) |=> chan_tick_o[c]);
  end
endmodule

bind pwm_pair_clkdiv pwm_pair_clkdiv_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_wr_i    (cfg_wr_i),
  .osc_tick_i  (osc_tick_i),
  .bus_tick_i  (bus_tick_i),
  .chan_tick_o (chan_tick_o),
  .gate_q      (gate_q),
  .bypass_q    (bypass_q),
  .exp_q       (exp_q),
  .div_cnt     (div_cnt),
  .sel_tick    (sel_tick)
);

// File: tb/pwm_pair_clkdiv_bench.sv
`timescale 1ns/1ps
module pwm_pair_clkdiv_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_tick_i = 1'b0;
  logic       bus_tick_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [1:0] src_sel_i = '0;
  logic [3:0] div_exp_i = '0;
  logic [1:0] gate_i = '0;
  logic [1:0] bypass_i = '0;
  logic [1:0] chan_tick_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_pair_clkdiv u_pwm_pair_clkdiv (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .bus_tick_i(bus_tick_i),
    .cfg_wr_i(cfg_wr_i), .src_sel_i(src_sel_i), .div_exp_i(div_exp_i),
    .gate_i(gate_i), .bypass_i(bypass_i), .chan_tick_o(chan_tick_o)
  );

  // {src, exp, gate, bypass, expected ch0, expected ch1} over 256 cycles:
  // osc ticks every cycle (256), bus ticks on even cycles (128)
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 4'd0,  2'b11, 2'b00, 9'd256, 9'd256}, // R2 R1
    {2'd0, 4'd3,  2'b11, 2'b00, 9'd32,  9'd32 }, // R2 R6
    {2'd1, 4'd2,  2'b11, 2'b00, 9'd32,  9'd32 }, // R1 bus
    {2'd2, 4'd1,  2'b01, 2'b00, 9'd64,  9'd0  }, // R1 R4
    {2'd3, 4'd4,  2'b11, 2'b10, 9'd8,   9'd128}, // R5
    {2'd0, 4'd8,  2'b11, 2'b00, 9'd1,   9'd1  }, // R2 max
    {2'd0, 4'd9,  2'b11, 2'b00, 9'd1,   9'd1  }, // R3
    {2'd0, 4'd15, 2'b11, 2'b01, 9'd256, 9'd1  }, // R3 R5
    {2'd1, 4'd15, 2'b11, 2'b00, 9'd0,   9'd0  }, // R3 bus
    {2'd0, 4'd0,  2'b00, 2'b11, 9'd0,   9'd0  }, // R4
    {2'd1, 4'd7,  2'b10, 2'b11, 9'd0,   9'd128}, // R4 R5
    {2'd0, 4'd5,  2'b11, 2'b00, 9'd8,   9'd8  }  // R2
  };

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [3:0] m,
                          input logic [1:0] g, input logic [1:0] b);
    @(negedge clk_i);
    osc_tick_i = 1'b0; bus_tick_i = 1'b0;
    src_sel_i = s; div_exp_i = m; gate_i = g; bypass_i = b; cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  // sample index i shows the response to the ticks driven at index i-1
  task automatic run_window(input int n, output int c0, output int c1,
                            output int f0, output int f1);
    c0 = 0; c1 = 0; f0 = -1; f1 = -1;
    for (int i = 0; i <= n; i++) begin
      if (chan_tick_o[0]) begin c0++; if (f0 < 0) f0 = i; end
      if (chan_tick_o[1]) begin c1++; if (f1 < 0) f1 = i; end
      if (i == n) begin
        osc_tick_i = 1'b0; bus_tick_i = 1'b0;
      end else begin
        osc_tick_i = 1'b1; bus_tick_i = (i % 2 == 0);
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, c1, f0, f1;
    repeat (3) @(negedge clk_i);
    check("R8 reset output", int'(chan_tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_window(16, c0, c1, f0, f1);
    check("R8 ch0 silent after reset", c0, 0);
    check("R8 ch1 silent after reset", c1, 0);

    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v][27:26], VEC[v][25:22], VEC[v][21:20], VEC[v][19:18]);
      run_window(256, c0, c1, f0, f1);
      check($sformatf("R2 vec%0d ch0", v), c0, int'(VEC[v][17:9]));
      check($sformatf("R2 vec%0d ch1", v), c1, int'(VEC[v][8:0]));
    end

    // R7 R9: first divided tick after write, M=2 on osc
    do_write(2'd0, 4'd2, 2'b01, 2'b00);
    run_window(20, c0, c1, f0, f1);
    check("R7 first divided tick index", f0, 4);
    check("R9 bypass first tick index", f1, -1);

    // R5 R9: bypass on ch1 only, tick one cycle after first source tick
    do_write(2'd0, 4'd3, 2'b10, 2'b10);
    run_window(8, c0, c1, f0, f1);
    check("R9 bypass first tick index", f1, 1);
    check("R5 bypass ch1 count", c1, 8);

    // R1: bus selected, bus_tick first at index 0, M=1 -> second bus tick at idx 2
    do_write(2'd1, 4'd1, 2'b01, 2'b00);
    run_window(12, c0, c1, f0, f1);
    check("R1 bus first divided index", f0, 3);

    // R7: rewrite partway through an interval restarts the phase
    do_write(2'd0, 4'd3, 2'b01, 2'b00);
    run_window(5, c0, c1, f0, f1);
    check("R7 no tick before rewrite", c0, 0);
    do_write(2'd0, 4'd3, 2'b01, 2'b00);
    run_window(16, c0, c1, f0, f1);
    check("R7 first tick after rewrite", f0, 8);
    check("R7 count after rewrite", c0, 2);

    // R8: asynchronous reset mid-run clears gates
    do_write(2'd0, 4'd0, 2'b11, 2'b11);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_window(10, c0, c1, f0, f1);
    check("R8 ch0 after mid reset", c0, 0);
    check("R8 ch1 after mid reset", c1, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule